// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Unit

This unit keeps the status register of a serial flash array and acts as the gatekeeper for every command that can change the array or the register. A command decoder upstream raises one strobe per command. Each strobe is either a latch command (arm or disarm writes) or a modifying command (status write carrying a data byte, page program, sector erase, bulk erase). The unit answers each strobe with a one-cycle accept or reject pulse. Program and erase strobes carry a target address. The unit weighs that address against the block-protect code, the write-enable latch, the busy flag and a hardware lock. The lock is formed by the status-write-disable bit together with the active-low write-protect pin.

An accepted modifying command raises the busy flag. The flag stays up until the array sequencer reports completion on `op_done`. Completion clears busy and the write-enable latch in the same edge. For a status write, completion is also the point where the new protect and lock bits take effect. The status byte can be read at any time, including while busy. Storage that is non-volatile in silicon is modelled here as ordinary registers cleared by reset.

Top module: `flash_wp_unit`

## Requirements
- R1: After a synchronous reset the status byte is 00h and neither `cmd_accept` nor `cmd_reject` is high.
- R2: The status byte is laid out with bit 0 = busy, bit 1 = write-enable latch, bit 2 = protect code low bit, bit 3 = protect code high bit, bit 7 = status-write-disable, and bits 6..4 always read 0.
- R3: When idle, the arm strobe sets the write-enable latch and the disarm strobe clears it. Either strobe is accepted, and the new latch value shows one cycle after the strobe.
- R4: A status write, page program, sector erase or bulk erase is rejected while the write-enable latch is 0.
- R5: Page program and sector erase are rejected when the top two address bits name a protected quarter. Protect code 00 protects none. Code 01 protects quarter 3. Code 10 protects quarters 2 and 3. Code 11 protects all four.
- R6: Bulk erase is accepted only when the protect code is 00.
- R7: While status-write-disable is 1 and `wp_n` is low, a status write is rejected and bits 7, 3 and 2 do not change.
- R8: An accepted modifying command sets busy one cycle after its strobe. Busy then holds until `op_done` is sampled high. That edge clears busy and the write-enable latch together, and applies a pending status write.
- R9: While busy, every strobe is rejected and has no effect. `op_done` sampled while idle changes nothing.
- R10: A rejected command leaves the write-enable latch and the rest of the status byte unchanged.
- R11: A status write updates only bits 7, 3 and 2. The values given for data bits 6..4, 1 and 0 are ignored.
- R12: Each cycle with at least one strobe produces exactly one of accept or reject in the next cycle, and a cycle with no strobe produces neither. Two or more strobes in the same cycle are rejected and have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wren | input | 1 | Arm strobe: set write-enable latch |
| cmd_wrdi | input | 1 | Disarm strobe: clear write-enable latch |
| cmd_wrsr | input | 1 | Status write strobe |
| wrsr_data | input | 8 | Data byte for the status write |
| cmd_pp | input | 1 | Page program strobe |
| cmd_se | input | 1 | Sector erase strobe |
| cmd_be | input | 1 | Bulk erase strobe |
| cmd_addr | input | ADDR_W | Target byte address of program or erase |
| wp_n | input | 1 | Write-protect pin, active low |
| op_done | input | 1 | Array sequencer reports end of the busy period |
| status | output | 8 | Status byte |
| cmd_accept | output | 1 | One-cycle pulse: command granted |
| cmd_reject | output | 1 | One-cycle pulse: command refused |

## Verification
The verdict for a strobe sampled at edge k appears on `cmd_accept`/`cmd_reject` right after edge k. The same holds for the latch and busy bits of the status byte. The bench drives each strobe at a falling edge and reads every result at the next falling edge, one register stage later. A completion pulse on `op_done` is read the same way. Its effect on busy, on the latch and on a pending status write is checked at the falling edge after the edge that sampled it. The sweep covers every protect code, lock bit, pin level and address quarter, and it predicts each verdict and status byte from a bench model of the requirements.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  localparam int STAT_W = 8;
  localparam int BIT_BUSY = 0;
  localparam int BIT_WEL  = 1;
  localparam int BIT_BPL  = 2;
  localparam int BIT_BPH  = 3;
  localparam int BIT_LOCK = 7;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ARM  = 3'd1,
    OP_DISARM = 3'd2,
    OP_SWR  = 3'd3,
    OP_PROG = 3'd4,
    OP_SERS = 3'd5,
    OP_BERS = 3'd6,
    OP_MULTI = 3'd7
  } op_t;

  // quarter index is the top two address bits; 3 is the highest quarter
  function automatic logic quarter_guarded(input logic [1:0] code, input logic [1:0] quarter);
    logic g;
    case (code)
      2'b00:   g = 1'b0;
      2'b01:   g = (quarter == 2'b11);
      2'b10:   g = quarter[1];
      default: g = 1'b1;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/fsp_cmd_decode.sv
module fsp_cmd_decode
  import fsp_pkg::*;
(
  input  logic cmd_wren,
  input  logic cmd_wrdi,
  input  logic cmd_wrsr,
  input  logic cmd_pp,
  input  logic cmd_se,
  input  logic cmd_be,
  output op_t  op,
  output logic any_strobe
);

  localparam int N_STROBE = 6;

  logic [N_STROBE-1:0] strobes;
  logic [$clog2(N_STROBE+1)-1:0] hits;

  assign strobes = {cmd_be, cmd_se, cmd_pp, cmd_wrsr, cmd_wrdi, cmd_wren};

  always_comb begin
    hits = '0;
    for (int i = 0; i < N_STROBE; i++) begin
      hits = hits + {{($clog2(N_STROBE+1)-1){1'b0}}, strobes[i]};
    end
  end

  assign any_strobe = |strobes;

  always_comb begin
    op = OP_NONE;
    if (hits > 1) begin
      op = OP_MULTI;
    end else begin
      unique case (1'b1)
        cmd_wren: op = OP_ARM;
        cmd_wrdi: op = OP_DISARM;
        cmd_wrsr: op = OP_SWR;
        cmd_pp:   op = OP_PROG;
        cmd_se:   op = OP_SERS;
        cmd_be:   op = OP_BERS;
        default:  op = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/fsp_guard.sv
module fsp_guard
  import fsp_pkg::*;
(
  input  op_t        op,
  input  logic [1:0] quarter,
  input  logic       busy,
  input  logic       wel,
  input  logic [1:0] prot_code,
  input  logic       lock_bit,
  input  logic       wp_n,
  output logic       grant
);

  logic hw_locked;
  logic target_guarded;

  assign hw_locked      = lock_bit & ~wp_n;
  assign target_guarded = quarter_guarded(prot_code, quarter);

  always_comb begin
    grant = 1'b0;
    if (!busy) begin
      case (op)
        OP_ARM, OP_DISARM: grant = 1'b1;
        OP_SWR:            grant = wel & ~hw_locked;
        OP_PROG, OP_SERS:  grant = wel & ~target_guarded;
        OP_BERS:           grant = wel & (prot_code == 2'b00);
        default:           grant = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/fsp_status_reg.sv
module fsp_status_reg
  import fsp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  op_t        op,
  input  logic       grant,
  input  logic [2:0] new_bits,   // {lock, prot_hi, prot_lo}
  input  logic       op_done,
  output logic       busy,
  output logic       wel,
  output logic [1:0] prot_code,
  output logic       lock_bit
);

  logic       pend_valid;
  logic [2:0] pend_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      wel        <= 1'b0;
      prot_code  <= 2'b00;
      lock_bit   <= 1'b0;
      pend_valid <= 1'b0;
      pend_bits  <= 3'b000;
    end else if (busy) begin
      if (op_done) begin
        busy <= 1'b0;
        wel  <= 1'b0;
        if (pend_valid) begin
          lock_bit   <= pend_bits[2];
          prot_code  <= pend_bits[1:0];
          pend_valid <= 1'b0;
        end
      end
    end else if (grant) begin
      case (op)
        OP_ARM:    wel <= 1'b1;
        OP_DISARM: wel <= 1'b0;
        OP_SWR: begin
          busy       <= 1'b1;
          pend_valid <= 1'b1;
          pend_bits  <= new_bits;
        end
        OP_PROG, OP_SERS, OP_BERS: busy <= 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/flash_wp_unit.sv
module flash_wp_unit
  import fsp_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              cmd_pp,
  input  logic              cmd_se,
  input  logic              cmd_be,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              wp_n,
  input  logic              op_done,
  output logic [7:0]        status,
  output logic              cmd_accept,
  output logic              cmd_reject
);

  localparam int Q_LSB = ADDR_W - 2;

  op_t        op;
  logic       any_strobe;
  logic       grant;
  logic       busy, wel, lock_bit;
  logic [1:0] prot_code;
  logic [1:0] quarter;
  logic       unused_bits;

  assign quarter     = cmd_addr[ADDR_W-1:Q_LSB];
  assign unused_bits = ^{cmd_addr[Q_LSB-1:0], wrsr_data[6:4], wrsr_data[1:0]};

  fsp_cmd_decode u_dec (
    .cmd_wren   (cmd_wren),
    .cmd_wrdi   (cmd_wrdi),
    .cmd_wrsr   (cmd_wrsr),
    .cmd_pp     (cmd_pp),
    .cmd_se     (cmd_se),
    .cmd_be     (cmd_be),
    .op         (op),
    .any_strobe (any_strobe)
  );

  fsp_guard u_guard (
    .op        (op),
    .quarter   (quarter),
    .busy      (busy),
    .wel       (wel),
    .prot_code (prot_code),
    .lock_bit  (lock_bit),
    .wp_n      (wp_n),
    .grant     (grant)
  );

  fsp_status_reg u_sreg (
    .clk       (clk),
    .rst       (rst),
    .op        (op),
    .grant     (grant),
    .new_bits  ({wrsr_data[BIT_LOCK], wrsr_data[BIT_BPH], wrsr_data[BIT_BPL]}),
    .op_done   (op_done),
    .busy      (busy),
    .wel       (wel),
    .prot_code (prot_code),
    .lock_bit  (lock_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_accept <= 1'b0;
      cmd_reject <= 1'b0;
    end else begin
      cmd_accept <= any_strobe & grant;
      cmd_reject <= any_strobe & ~grant;
    end
  end

  always_comb begin
    status           = '0;
    status[BIT_BUSY] = busy;
    status[BIT_WEL]  = wel;
    status[BIT_BPL]  = prot_code[0];
    status[BIT_BPH]  = prot_code[1];
    status[BIT_LOCK] = lock_bit;
  end

endmodule

// File: rtl/fsp_checks.sv
module fsp_checks #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_wren,
  input logic              cmd_wrdi,
  input logic              cmd_wrsr,
  input logic              cmd_pp,
  input logic              cmd_se,
  input logic              cmd_be,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              wp_n,
  input logic              op_done,
  input logic [7:0]        status,
  input logic              cmd_accept,
  input logic              cmd_reject
);

  logic strobe, modify;
  assign strobe = cmd_wren | cmd_wrdi | cmd_wrsr | cmd_pp | cmd_se | cmd_be;
  assign modify = cmd_wrsr | cmd_pp | cmd_se | cmd_be;

  p_zero_bits_r2: assert property (@(posedge clk) disable iff (rst)
    status[6:4] == 3'b000);

  p_no_latch_r4: assert property (@(posedge clk) disable iff (rst)
    modify && !status[1] |=> cmd_reject);

  p_top_quarter_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_pp || cmd_se) && status[3:2] != 2'b00 && cmd_addr[ADDR_W-1:ADDR_W-2] == 2'b11
    |=> cmd_reject);

  p_bulk_guard_r6: assert property (@(posedge clk) disable iff (rst)
    cmd_be && status[3:2] != 2'b00 |=> cmd_reject);

  p_lock_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_wrsr && status[7] && !wp_n |=> cmd_reject && status[7:2] == $past(status[7:2]));

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    status[0] && !op_done |=> status[0]);

  p_done_clear_r8: assert property (@(posedge clk) disable iff (rst)
    status[0] && op_done |=> status[1:0] == 2'b00);

  p_busy_reject_r9: assert property (@(posedge clk) disable iff (rst)
    status[0] && strobe |=> cmd_reject);

  p_one_verdict_r12: assert property (@(posedge clk) disable iff (rst)
    !(cmd_accept && cmd_reject));

  p_verdict_r12: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (cmd_accept || cmd_reject));

  p_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> !cmd_accept && !cmd_reject);

endmodule

bind flash_wp_unit fsp_checks #(.ADDR_W(ADDR_W)) u_fsp_checks (
  .clk        (clk),
  .rst        (rst),
  .cmd_wren   (cmd_wren),
  .cmd_wrdi   (cmd_wrdi),
  .cmd_wrsr   (cmd_wrsr),
  .cmd_pp     (cmd_pp),
  .cmd_se     (cmd_se),
  .cmd_be     (cmd_be),
  .cmd_addr   (cmd_addr),
  .wp_n       (wp_n),
  .op_done    (op_done),
  .status     (status),
  .cmd_accept (cmd_accept),
  .cmd_reject (cmd_reject)
);

// File: tb/test_flash_wp_unit.sv
module test_flash_wp_unit;

  localparam int ADDR_W = 17;
  localparam int QSIZE  = 1 << (ADDR_W - 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_pp = 0, cmd_se = 0, cmd_be = 0;
  logic [7:0] wrsr_data = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic wp_n = 1'b1;
  logic op_done = 1'b0;
  logic [7:0] status;
  logic cmd_accept, cmd_reject;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // bench model of the status register
  bit m_lock, m_wel, m_busy, m_pend;
  bit [1:0] m_prot;
  bit [2:0] m_pbits;

  always #4 clk = ~clk;

  flash_wp_unit #(.ADDR_W(ADDR_W)) i_flash_wp_unit (
    .clk, .rst, .cmd_wren, .cmd_wrdi, .cmd_wrsr, .wrsr_data, .cmd_pp, .cmd_se,
    .cmd_be, .cmd_addr, .wp_n, .op_done, .status, .cmd_accept, .cmd_reject
  );

  function automatic logic [7:0] m_status();
    return {m_lock, 3'b000, m_prot, m_wel, m_busy};
  endfunction

  function automatic bit guarded(bit [1:0] code, int q);
    return (code == 2'd3) || (code == 2'd2 && q >= 2) || (code == 2'd1 && q == 3);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // op: 1 arm, 2 disarm, 3 status write, 4 program, 5 sector erase, 6 bulk erase
  task automatic run_cmd(int op, logic [ADDR_W-1:0] a, logic [7:0] d, string req);
    bit g;
    int q;
    q = int'(a[ADDR_W-1:ADDR_W-2]);
    if (m_busy) g = 0;
    else case (op)
      1, 2:    g = 1;
      3:       g = m_wel && !(m_lock && !wp_n);
      4, 5:    g = m_wel && !guarded(m_prot, q);
      default: g = m_wel && (m_prot == 2'd0);
    endcase
    @(negedge clk);
    cmd_addr  = a;
    wrsr_data = d;
    cmd_wren = (op == 1); cmd_wrdi = (op == 2); cmd_wrsr = (op == 3);
    cmd_pp   = (op == 4); cmd_se   = (op == 5); cmd_be   = (op == 6);
    @(negedge clk);
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be} = '0;
    if (g) begin
      case (op)
        1: m_wel = 1;
        2: m_wel = 0;
        3: begin m_busy = 1; m_pend = 1; m_pbits = {d[7], d[3], d[2]}; end
        default: m_busy = 1;
      endcase
    end
    check({req, " verdict"}, {30'd0, cmd_accept, cmd_reject}, {30'd0, g, !g});
    check({req, " status"}, status, m_status());
  endtask

  task automatic pulse_done(string req);
    @(negedge clk);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
    if (m_busy) begin
      m_busy = 0; m_wel = 0;
      if (m_pend) begin m_lock = m_pbits[2]; m_prot = m_pbits[1:0]; m_pend = 0; end
    end
    check({req, " after done"}, status, m_status());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 reset status", status, 8'h00);
    check("R1 reset verdicts", {cmd_accept, cmd_reject}, 2'b00);

    // R4: modifying commands with latch clear
    run_cmd(4, '0, 8'h00, "R4 program no latch");
    run_cmd(5, '0, 8'h00, "R4 erase no latch");
    run_cmd(6, '0, 8'h00, "R4 bulk no latch");
    run_cmd(3, '0, 8'h8C, "R4 swrite no latch");

    // R3: arm / disarm, R2 latch bit position
    run_cmd(1, '0, 8'h00, "R3 arm");
    check("R2 latch at bit1", status, 8'h02);
    run_cmd(2, '0, 8'h00, "R3 disarm");
    run_cmd(2, '0, 8'h00, "R3 disarm twice");

    // R8/R9: busy window
    run_cmd(1, '0, 8'h00, "R3 arm before program");
    run_cmd(4, 17'h00123, 8'h00, "R8 program accepted");
    check("R2 busy at bit0", status, 8'h03);
    repeat (5) @(negedge clk);
    check("R8 busy holds", status, m_status());
    run_cmd(1, '0, 8'h00, "R9 arm while busy");
    run_cmd(2, '0, 8'h00, "R9 disarm while busy");
    run_cmd(6, '0, 8'h00, "R9 bulk while busy");
    pulse_done("R8 completion");
    pulse_done("R9 stray done");

    // R12: two strobes at once
    @(negedge clk);
    cmd_wren = 1; cmd_wrdi = 1;
    @(negedge clk);
    cmd_wren = 0; cmd_wrdi = 0;
    check("R12 multi verdict", {cmd_accept, cmd_reject}, 2'b01);
    check("R12 multi status", status, m_status());
    @(negedge clk);
    check("R12 quiet", {cmd_accept, cmd_reject}, 2'b00);

    // sweep: protect code x lock bit x pin x quarter
    for (int bp = 0; bp < 4; bp++) begin
      for (int lk = 0; lk < 2; lk++) begin
        for (int pin = 0; pin < 2; pin++) begin
          wp_n = 1'b1;
          run_cmd(1, '0, 8'h00, "R3 arm config");
          // R11: ones in ignored positions
          run_cmd(3, '0, {lk[0], 3'b111, bp[1:0], 2'b11}, "R11 configure");
          pulse_done("R11 configured");
          wp_n = pin[0];
          for (int q = 0; q < 4; q++) begin
            logic [ADDR_W-1:0] a;
            a = ADDR_W'(q * QSIZE + q * 1000 + 5);
            run_cmd(1, '0, 8'h00, "R3 arm");
            run_cmd(4, a, 8'h00, "R5 program quarter");
            if (m_busy) pulse_done("R8 program done");
            else run_cmd(2, '0, 8'h00, "R10 disarm after reject");
            run_cmd(1, '0, 8'h00, "R3 arm");
            run_cmd(5, a, 8'h00, "R5 erase quarter");
            if (m_busy) pulse_done("R8 erase done");
            else run_cmd(2, '0, 8'h00, "R10 disarm after reject");
          end
          run_cmd(1, '0, 8'h00, "R3 arm");
          run_cmd(6, '0, 8'h00, "R6 bulk");
          if (m_busy) pulse_done("R8 bulk done");
          else run_cmd(2, '0, 8'h00, "R10 disarm after reject");
          run_cmd(1, '0, 8'h00, "R3 arm");
          run_cmd(3, '0, {~lk[0], 3'b101, ~bp[1:0], 2'b10}, "R7 status write under pin");
          if (m_busy) pulse_done("R7 swrite done");
          else run_cmd(2, '0, 8'h00, "R10 disarm after reject");
        end
      end
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule